// File: doc/BRIEF.md
# OSD Serial Packet Format Decoder

This block sits behind a serial slave front end (SPI or I2C) of an on-screen display controller. The front end hands it one received byte at a time, plus a frame-start pulse when a transaction opens and a frame-end pulse when it closes. The decoder classifies every byte by its tag bits and its position in the packet: a row address, a column address or a data byte. It then issues single-cycle write commands to one of three targets: the character-code plane of the display memory, the attribute plane, or the user-font RAM.

Three packet shapes are accepted inside a frame. In the first, every write carries its own row, column and data. In the second, one row is followed by repeated column/data pairs. In the third, the bulk shape, a single row and a single column are followed by an unbroken run of data bytes. The position advances by itself after each of those data bytes. Once a frame has entered the bulk shape, it stays there until the frame ends or a new frame starts.

Top module: `osd_pkt_decoder`

## Requirements
- R1: After reset, wr_stb is 0, wr_tgt, wr_row, wr_col and wr_data are 0, and the parser is outside any frame.
- R2: Bytes that arrive before the first frame start, or after a frame end and before the next frame start, produce no write. A frame start puts the parser in the row-expected state. A byte presented in the same cycle as the frame start is parsed as the first byte of the new frame. A frame start in the middle of a frame abandons the old packet.
- R3: A byte with bit7 = 1 is a row byte. Bit6 = 1 selects the user-font RAM (wr_tgt = 2), with the row taken from bits 2..0. Bit6 = 0 selects the display, with the row taken from bits 4..0: bit5 = 0 selects the character-code plane (wr_tgt = 0) and bit5 = 1 selects the attribute plane (wr_tgt = 1). wr_tgt is never 3.
- R4: A byte with bit7 = 0, accepted where a column is allowed, is a column byte. The column is taken from bits 5..0 for the font RAM and from bits 4..0 for the display. Bit6 = 1 enters the bulk shape and bit6 = 0 expects exactly one data byte. For the character-code plane, bit5 is latched as the ninth data bit.
- R5: Outside the bulk shape, the single byte after a column byte is data, whatever its bit7, and the position does not advance. After that data byte, either a row byte or a column byte is accepted.
- R6: Each data byte yields exactly one wr_stb pulse, in the cycle after the byte is accepted. In that cycle, wr_tgt, wr_row and wr_col hold the current target and position. wr_data is {ninth bit, byte} for the character-code plane and {0, byte} for the other targets.
- R7: In the bulk shape, every byte is data, including bytes with bit7 = 1, until the frame ends. The latched ninth bit applies to every one of them.
- R8: In the bulk shape on the display, the column increments after each write. After column DISP_COLS-1 (29) it wraps to 0 and the row increments. After row DISP_ROWS-1 (14), the row wraps to 0.
- R9: In the bulk shape on the font RAM, the column wraps after FONT_COLS-1 (63), and the row wraps after FONT_ROWS-1 (7).
- R10: A byte whose tag does not fit the parser state is dropped and leaves the state unchanged. This covers a column byte when a row is expected, and a row byte when a column is expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Pulse: a transaction opens |
| frm_end | input | 1 | Pulse: a transaction closes (a byte in the same cycle is still parsed) |
| byte_vld | input | 1 | byte_in holds a received byte |
| byte_in | input | 8 | Received byte |
| wr_stb | output | 1 | Single-cycle write command |
| wr_tgt | output | 2 | 0 character code, 1 attribute, 2 user font |
| wr_row | output | 5 | Write row |
| wr_col | output | 6 | Write column |
| wr_data | output | 9 | Write data word |

## Verification
The bench drives bulk runs across the last column and the last row. A stepper with the wrong limit would write column 30, or would fail to return to row 0. It also sends a bulk data byte with bit7 set: a parser that still decoded tags in the bulk shape would take that byte as a new row and drop the write. Out-of-order tags are fed where a row or a column is expected, and bytes are sent outside any frame. A permissive parser would emit stray writes or move its position, and the scoreboard reports those as unexpected strobes or wrong coordinates. The ninth bit is checked on the attribute plane, where a leak of the latched bit would show as wr_data[8] = 1.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;

    typedef enum logic [1:0] {
        TGT_CHAR = 2'd0,
        TGT_ATTR = 2'd1,
        TGT_FONT = 2'd2
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_DATA = 3'd3,
        ST_ANY  = 3'd4,
        ST_BULK = 3'd5
    } pst_e;

endpackage

// File: rtl/osd_byte_classifier.sv
module osd_byte_classifier
    import osd_dec_pkg::*;
#(
    parameter int ROW_W = 5,
    parameter int COL_W = 6
) (
    input  logic [7:0]       byte_i,
    input  logic             cur_is_font,
    output logic             is_row,
    output tgt_e             row_tgt,
    output logic [ROW_W-1:0] row_val,
    output logic [COL_W-1:0] col_val,
    output logic             col_bulk,
    output logic             col_ninth
);
    always_comb begin
        is_row    = byte_i[7];
        col_bulk  = byte_i[6];
        col_ninth = byte_i[5];
        if (byte_i[6]) begin
            row_tgt = TGT_FONT;
            row_val = ROW_W'(byte_i[2:0]);
        end else begin
            row_tgt = byte_i[5] ? TGT_ATTR : TGT_CHAR;
            row_val = ROW_W'(byte_i[4:0]);
        end
        col_val = cur_is_font ? COL_W'(byte_i[5:0]) : COL_W'(byte_i[4:0]);
    end
endmodule

// File: rtl/osd_pos_step.sv
module osd_pos_step #(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int DISP_ROWS = 15,
    parameter int DISP_COLS = 30,
    parameter int FONT_ROWS = 8,
    parameter int FONT_COLS = 64
) (
    input  logic             is_font,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    localparam logic [ROW_W-1:0] DISP_LAST_R = ROW_W'(DISP_ROWS - 1);
    localparam logic [COL_W-1:0] DISP_LAST_C = COL_W'(DISP_COLS - 1);
    localparam logic [ROW_W-1:0] FONT_LAST_R = ROW_W'(FONT_ROWS - 1);
    localparam logic [COL_W-1:0] FONT_LAST_C = COL_W'(FONT_COLS - 1);

    logic [ROW_W-1:0] last_r;
    logic [COL_W-1:0] last_c;

    always_comb begin
        last_r = is_font ? FONT_LAST_R : DISP_LAST_R;
        last_c = is_font ? FONT_LAST_C : DISP_LAST_C;
        if (col_i >= last_c) begin
            col_o = '0;
            row_o = (row_i >= last_r) ? '0 : row_i + 1'b1;
        end else begin
            col_o = col_i + 1'b1;
            row_o = row_i;
        end
    end
endmodule

// File: rtl/osd_pkt_decoder.sv
module osd_pkt_decoder
    import osd_dec_pkg::*;
#(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int DISP_ROWS = 15,
    parameter int DISP_COLS = 30,
    parameter int FONT_ROWS = 8,
    parameter int FONT_COLS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    output logic             wr_stb,
    output logic [1:0]       wr_tgt,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [8:0]       wr_data
);
    typedef struct packed {
        pst_e             st;
        tgt_e             tgt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ninth;
        logic             stb;
        tgt_e             o_tgt;
        logic [ROW_W-1:0] o_row;
        logic [COL_W-1:0] o_col;
        logic [8:0]       o_data;
    } dec_t;

    dec_t s_d, s_q;

    logic             cls_is_row;
    tgt_e             cls_tgt;
    logic [ROW_W-1:0] cls_row;
    logic [COL_W-1:0] cls_col;
    logic             cls_bulk;
    logic             cls_ninth;
    logic [ROW_W-1:0] nxt_row;
    logic [COL_W-1:0] nxt_col;
    pst_e             base_st;

    osd_byte_classifier #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
        .byte_i      (byte_in),
        .cur_is_font (s_q.tgt == TGT_FONT),
        .is_row      (cls_is_row),
        .row_tgt     (cls_tgt),
        .row_val     (cls_row),
        .col_val     (cls_col),
        .col_bulk    (cls_bulk),
        .col_ninth   (cls_ninth)
    );

    osd_pos_step #(
        .ROW_W(ROW_W), .COL_W(COL_W),
        .DISP_ROWS(DISP_ROWS), .DISP_COLS(DISP_COLS),
        .FONT_ROWS(FONT_ROWS), .FONT_COLS(FONT_COLS)
    ) u_step (
        .is_font (s_q.tgt == TGT_FONT),
        .row_i   (s_q.row),
        .col_i   (s_q.col),
        .row_o   (nxt_row),
        .col_o   (nxt_col)
    );

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        base_st = frm_start ? ST_ROW : s_q.st;
        s_d.st  = base_st;

        if (byte_vld) begin
            case (base_st)
                ST_ROW, ST_COL, ST_ANY: begin
                    if (cls_is_row && base_st != ST_COL) begin
                        s_d.tgt = cls_tgt;
                        s_d.row = cls_row;
                        s_d.st  = ST_COL;
                    end else if (!cls_is_row && base_st != ST_ROW) begin
                        s_d.col = cls_col;
                        s_d.st  = cls_bulk ? ST_BULK : ST_DATA;
                        if (s_q.tgt == TGT_CHAR) begin
                            s_d.ninth = cls_ninth;
                        end
                    end
                end
                ST_DATA, ST_BULK: begin
                    s_d.stb    = 1'b1;
                    s_d.o_tgt  = s_q.tgt;
                    s_d.o_row  = s_q.row;
                    s_d.o_col  = s_q.col;
                    s_d.o_data = {(s_q.tgt == TGT_CHAR) & s_q.ninth, byte_in};
                    if (base_st == ST_BULK) begin
                        s_d.row = nxt_row;
                        s_d.col = nxt_col;
                    end else begin
                        s_d.st = ST_ANY;
                    end
                end
                default: ;
            endcase
        end

        if (frm_end) begin
            s_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_stb  = s_q.stb;
    assign wr_tgt  = s_q.o_tgt;
    assign wr_row  = s_q.o_row;
    assign wr_col  = s_q.o_col;
    assign wr_data = s_q.o_data;

endmodule

// File: rtl/osd_pkt_decoder_chk.sv
module osd_pkt_decoder_chk #(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 6,
    parameter int DISP_ROWS = 15,
    parameter int DISP_COLS = 30,
    parameter int FONT_ROWS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             wr_stb,
    input logic [1:0]       wr_tgt,
    input logic [ROW_W-1:0] wr_row,
    input logic [COL_W-1:0] wr_col,
    input logic [8:0]       wr_data
);
    localparam logic [ROW_W-1:0] DR = ROW_W'(DISP_ROWS);
    localparam logic [COL_W-1:0] DC = COL_W'(DISP_COLS);
    localparam logic [ROW_W-1:0] FR = ROW_W'(FONT_ROWS);

    assert_stb_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(byte_vld));

    assert_tgt_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> wr_tgt != 2'd3);

    assert_disp_col_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_tgt != 2'd2) |-> wr_col < DC);

    assert_disp_row_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_tgt != 2'd2) |-> wr_row < DR);

    assert_font_row_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_tgt == 2'd2) |-> wr_row < FR);

    assert_ninth_char_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_tgt != 2'd0) |-> !wr_data[8]);

endmodule

bind osd_pkt_decoder osd_pkt_decoder_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .DISP_ROWS(DISP_ROWS), .DISP_COLS(DISP_COLS), .FONT_ROWS(FONT_ROWS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .wr_stb(wr_stb),
    .wr_tgt(wr_tgt), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
);

// File: tb/osd_pkt_decoder_tb.sv
module osd_pkt_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       frm_end = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       wr_stb;
    logic [1:0] wr_tgt;
    logic [4:0] wr_row;
    logic [5:0] wr_col;
    logic [8:0] wr_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0] tgt;
        logic [4:0] row;
        logic [5:0] col;
        logic [8:0] data;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    osd_pkt_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
        .byte_vld(byte_vld), .byte_in(byte_in), .wr_stb(wr_stb),
        .wr_tgt(wr_tgt), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    // monitor: compares every strobe against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2/R10 unexpected write tgt=%0d row=%0d col=%0d data=%h, expected none",
                         wr_tgt, wr_row, wr_col, wr_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if ({wr_tgt, wr_row, wr_col, wr_data} !== e) begin
                    failures++;
                    $display("FAIL R6 write actual tgt=%0d row=%0d col=%0d data=%h expected tgt=%0d row=%0d col=%0d data=%h",
                             wr_tgt, wr_row, wr_col, wr_data, e.tgt, e.row, e.col, e.data);
                end
            end
        end
    end

    task automatic expect_wr(input logic [1:0] t, input int r, input int c, input logic [8:0] d);
        exp_q.push_back({t, 5'(r), 6'(c), d});
    endtask

    task automatic send(input logic [7:0] b, input bit s = 1'b0, input bit e = 1'b0);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = b; frm_start = s; frm_end = e;
        @(negedge clk);
        byte_vld = 1'b0; frm_start = 1'b0; frm_end = 1'b0;
    endtask

    task automatic mark(input bit s, input bit e);
        @(negedge clk);
        frm_start = s; frm_end = e;
        @(negedge clk);
        frm_start = 1'b0; frm_end = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing writes actual=%0d pending expected=0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (wr_stb !== 1'b0) begin
            failures++; $display("FAIL R1 wr_stb actual=%b expected=0", wr_stb);
        end
        checks++;
        if ({wr_tgt, wr_row, wr_col, wr_data} !== '0) begin
            failures++; $display("FAIL R1 outputs actual=%h expected=0", {wr_tgt, wr_row, wr_col, wr_data});
        end
        rst_n = 1'b1;

        // R2: bytes before any frame are ignored
        send(8'h80); send(8'h00); send(8'h41);
        drain("R2");

        // R3/R5 first shape: row,col,data repeated; ninth bit on char plane
        mark(1'b1, 1'b0);
        send(8'h83); send(8'h25);
        expect_wr(2'd0, 3, 5, 9'h17A); send(8'h7A);
        send(8'hA4); send(8'h27);
        expect_wr(2'd1, 4, 7, 9'h055); send(8'h55);
        mark(1'b0, 1'b1);
        drain("R3");

        // R4/R5 second shape: one row, column/data pairs; then font target
        mark(1'b1, 1'b0);
        send(8'h81);
        send(8'h02); expect_wr(2'd0, 1, 2, 9'h011); send(8'h11);
        send(8'h23); expect_wr(2'd0, 1, 3, 9'h122); send(8'h22);
        send(8'hC5); send(8'h2A);
        expect_wr(2'd2, 5, 42, 9'h099); send(8'h99);
        // R5: data byte with bit7 set outside bulk is still data
        send(8'h03); expect_wr(2'd2, 5, 3, 9'h0C8); send(8'hC8);
        mark(1'b0, 1'b1);
        drain("R4");

        // R10 tag mismatches are dropped
        mark(1'b1, 1'b0);
        send(8'h05);
        send(8'h82); send(8'h86);
        send(8'h01); expect_wr(2'd0, 2, 1, 9'h0AB); send(8'hAB);
        mark(1'b0, 1'b1);
        drain("R10");

        // R7/R8 bulk on char plane across last column and last row
        mark(1'b1, 1'b0);
        send(8'h8E); send(8'h7C);
        expect_wr(2'd0, 14, 28, 9'h110); send(8'h10);
        expect_wr(2'd0, 14, 29, 9'h191); send(8'h91);
        expect_wr(2'd0, 0, 0, 9'h105); send(8'h05);
        expect_wr(2'd0, 0, 1, 9'h142); send(8'h42, 1'b0, 1'b1);
        drain("R8");

        // R2: bytes after frame end are ignored
        send(8'h83); send(8'h01); send(8'h44);
        drain("R2");

        // R2: frame start in the same cycle as the first byte
        send(8'h85, 1'b1);
        send(8'h00); expect_wr(2'd0, 5, 0, 9'h033); send(8'h33);
        mark(1'b0, 1'b1);
        drain("R2");

        // R8 attribute bulk wrap, R2 mid-frame restart, R9 font bulk wrap
        mark(1'b1, 1'b0);
        send(8'hA0); send(8'h5D);
        expect_wr(2'd1, 0, 29, 9'h0FF); send(8'hFF);
        expect_wr(2'd1, 1, 0, 9'h000); send(8'h00);
        mark(1'b1, 1'b0);
        send(8'hC7); send(8'h7F);
        expect_wr(2'd2, 7, 63, 9'h001); send(8'h01);
        expect_wr(2'd2, 0, 0, 9'h002); send(8'h02);
        mark(1'b0, 1'b1);
        drain("R9");

        // R7: a long bulk run over a whole row; bit7 bytes stay data
        mark(1'b1, 1'b0);
        send(8'h80); send(8'h60);
        for (int i = 0; i < 32; i++) begin
            expect_wr(2'd0, (i >= 30) ? 1 : 0, i % 30, {1'b1, 8'(8'h80 + i)});
            send(8'(8'h80 + i));
        end
        mark(1'b0, 1'b1);
        drain("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule